// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Periodic Interrupt

This block is a timebase for a small controller. A counter advances by one on every tick of a programmable prescaler. It wraps freely and cannot be written, started or stopped. A set of compare channels flags the tick on which the counter passes a programmed value, so software can measure elapsed time. An overflow flag marks each wrap.

A second, independent divider counts raw clocks and raises a periodic real-time flag. Its rate is chosen by two control bits. Every flag has an enable bit, and one interrupt request line is the OR of all flags that are both set and enabled.

Software reaches the block through a simple synchronous register port. A write takes effect on the clock edge on which `wr_en` is high. A read is combinational from `addr`. The register map is as follows:

- address 0: counter value (read-only)
- address 1: control register. Bits 1:0 hold the real-time rate. Bits 3:2 hold the prescaler select.
- address 2: flags
- address 3: enables
- addresses 4 upward: one compare register per channel

The flag bit positions are: bit 0 overflow, bit 1 real-time, and bit 2+i for compare channel i. The enable register uses the same positions.

Top module: `prescaled_timer`

## Requirements
- R1: The counter increases by exactly 1 (modulo 2^CNT_W) on each prescaler tick, holds between ticks, and ignores writes to address 0.
- R2: Prescaler select codes 0, 1, 2 and 3 in control bits 3:2 space counter increments 1, 4, 8 and 16 clocks apart.
- R3: The prescaler select can be changed only during the first LOCK_CYCLES (64 by default) clocks after reset. A later write leaves control bits 3:2 unchanged.
- R4: Flag bit 0 is set on the tick on which the counter wraps from its all-ones value to 0.
- R5: Flag bit 2+i is set on the tick on which the counter equals compare register i (address 4+i). That flag is therefore visible when the counter first shows the compare value plus one.
- R6: With rate code c in control bits 1:0, flag bit 1 is set once every 2^(RTI_BASE_LOG2+c) clocks. The rate bits stay writable at all times.
- R7: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R8: `irq` is high exactly when some flag bit and the enable bit in the same position (address 3) are both 1.
- R9: After reset, the counter, control, flags and enables read 0, every compare register reads all ones, and `irq` is low.
- R10: `rd_data` shows the register selected by `addr` in the same cycle. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Read data for `addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
Every flag is registered, so it becomes visible one clock after the edge on which its cause holds. A compare or overflow flag is therefore checked at the same sample where the counter first shows the next value. Register writes are checked at the first falling edge after the writing edge, and reads and `irq` are checked combinationally in the same low phase. Prescaler and real-time rates are checked as exact gaps between successive observed events, using a bench clock-edge counter. The first events after a rate change are discarded, so that a partial period cannot skew the measurement.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
   localparam int unsigned FLG_OVF      = 0;
   localparam int unsigned FLG_RTI      = 1;
   localparam int unsigned FLG_CMP_BASE = 2;

   localparam int unsigned RA_COUNT    = 0;
   localparam int unsigned RA_CTRL     = 1;
   localparam int unsigned RA_FLAGS    = 2;
   localparam int unsigned RA_ENABLE   = 3;
   localparam int unsigned RA_CMP_BASE = 4;

   typedef enum logic [1:0] {
      PS_DIV1  = 2'd0,
      PS_DIV4  = 2'd1,
      PS_DIV8  = 2'd2,
      PS_DIV16 = 2'd3
   } ps_sel_e;

   // last prescaler phase before a tick, i.e. divisor minus one
   function automatic logic [3:0] ps_last(input logic [1:0] sel);
      case (ps_sel_e'(sel))
         PS_DIV1:  ps_last = 4'd0;
         PS_DIV4:  ps_last = 4'd3;
         PS_DIV8:  ps_last = 4'd7;
         default:  ps_last = 4'd15;
      endcase
   endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
   parameter int unsigned LOCK_CYCLES = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_we,
   input  logic [1:0] sel_d,
   output logic [1:0] sel_q,
   output logic       tick
);
   localparam int unsigned LK_W = $clog2(LOCK_CYCLES + 1);

   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("tmr_prescaler: LOCK_CYCLES must be at least 1");
   end

   logic [LK_W-1:0] age;
   logic            locked;
   logic [3:0]      phase;

   assign locked = (age == LK_W'(LOCK_CYCLES));

   always_ff @(posedge clk) begin
      if (!rst_n)       age <= '0;
      else if (!locked) age <= age + LK_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 sel_q <= 2'd0;
      else if (sel_we && !locked) sel_q <= sel_d;
   end

   assign tick = (phase >= tmr_pkg::ps_last(sel_q));

   always_ff @(posedge clk) begin
      if (!rst_n)    phase <= 4'd0;
      else if (tick) phase <= 4'd0;
      else           phase <= phase + 4'd1;
   end

   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && sel_we) |=> $stable(sel_q)); // R3
   AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked); // R3
endmodule

// File: rtl/tmr_rti.sv
`timescale 1ns/1ps
module tmr_rti #(
   parameter int unsigned BASE_LOG2 = 13
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate,
   output logic       pulse
);
   localparam int unsigned DW = BASE_LOG2 + 3;

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("tmr_rti: BASE_LOG2 must be at least 1");
   end

   logic [DW-1:0] dcnt;
   logic [DW-1:0] last;

   assign last  = {DW{1'b1}} >> (2'd3 - rate);
   assign pulse = (dcnt >= last);

   always_ff @(posedge clk) begin
      if (!rst_n)     dcnt <= '0;
      else if (pulse) dcnt <= '0;
      else            dcnt <= dcnt + DW'(1);
   end

   AST_RTI_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R6
endmodule

// File: rtl/tmr_cmp_chan.sv
`timescale 1ns/1ps
module tmr_cmp_chan #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] wd,
   input  logic [CNT_W-1:0] count,
   input  logic             tick,
   output logic [CNT_W-1:0] val,
   output logic             hit
);
   always_ff @(posedge clk) begin
      if (!rst_n)  val <= '1;
      else if (we) val <= wd;
   end

   assign hit = tick && (count == val);

   AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(val)); // R5
endmodule

// File: rtl/prescaled_timer.sv
`timescale 1ns/1ps
module prescaled_timer #(
   parameter int unsigned CNT_W         = 16,
   parameter int unsigned NUM_CMP       = 4,
   parameter int unsigned RTI_BASE_LOG2 = 13,
   parameter int unsigned LOCK_CYCLES   = 64,
   parameter int unsigned ADDR_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  rd_data,
   output logic              irq
);
   import tmr_pkg::*;

   localparam int unsigned FLG_W = FLG_CMP_BASE + NUM_CMP;

   if (NUM_CMP < 1) begin : g_bad_ncmp
      $error("prescaled_timer: NUM_CMP must be at least 1");
   end
   if (CNT_W < 4 || CNT_W < FLG_W) begin : g_bad_cntw
      $error("prescaled_timer: CNT_W too narrow for control or flags");
   end
   if ((RA_CMP_BASE + NUM_CMP) > (1 << ADDR_W)) begin : g_bad_addr
      $error("prescaled_timer: ADDR_W too small for the compare registers");
   end

   logic we_ctrl, we_flags, we_en;
   assign we_ctrl  = wr_en && (addr == ADDR_W'(RA_CTRL));
   assign we_flags = wr_en && (addr == ADDR_W'(RA_FLAGS));
   assign we_en    = wr_en && (addr == ADDR_W'(RA_ENABLE));

   logic [1:0] ps_sel;
   logic       tick;

   tmr_prescaler #(.LOCK_CYCLES(LOCK_CYCLES)) u_ps (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_we (we_ctrl),
      .sel_d  (wr_data[3:2]),
      .sel_q  (ps_sel),
      .tick   (tick)
   );

   logic [1:0] rti_rate;
   logic       rti_pulse;

   always_ff @(posedge clk) begin
      if (!rst_n)       rti_rate <= 2'd0;
      else if (we_ctrl) rti_rate <= wr_data[1:0];
   end

   tmr_rti #(.BASE_LOG2(RTI_BASE_LOG2)) u_rti (
      .clk   (clk),
      .rst_n (rst_n),
      .rate  (rti_rate),
      .pulse (rti_pulse)
   );

   logic [CNT_W-1:0] count;
   logic             ovf_evt;

   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (tick) count <= count + CNT_W'(1);
   end

   assign ovf_evt = tick && (count == {CNT_W{1'b1}});

   logic [CNT_W-1:0] cmp_val [NUM_CMP];
   logic [NUM_CMP-1:0] cmp_hit;

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      tmr_cmp_chan #(.CNT_W(CNT_W)) u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && (addr == ADDR_W'(RA_CMP_BASE + i))),
         .wd    (wr_data),
         .count (count),
         .tick  (tick),
         .val   (cmp_val[i]),
         .hit   (cmp_hit[i])
      );
   end

   logic [FLG_W-1:0] flags, enables, set_mask, clr_mask;

   always_comb begin
      set_mask          = '0;
      set_mask[FLG_OVF] = ovf_evt;
      set_mask[FLG_RTI] = rti_pulse;
      for (int i = 0; i < NUM_CMP; i++) set_mask[FLG_CMP_BASE + i] = cmp_hit[i];
   end

   assign clr_mask = we_flags ? wr_data[FLG_W-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_mask) | set_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     enables <= '0;
      else if (we_en) enables <= wr_data[FLG_W-1:0];
   end

   assign irq = |(flags & enables);

   always_comb begin
      rd_data = '0;
      if (addr == ADDR_W'(RA_COUNT))       rd_data = count;
      else if (addr == ADDR_W'(RA_CTRL))   rd_data = CNT_W'({ps_sel, rti_rate});
      else if (addr == ADDR_W'(RA_FLAGS))  rd_data = CNT_W'(flags);
      else if (addr == ADDR_W'(RA_ENABLE)) rd_data = CNT_W'(enables);
      for (int i = 0; i < NUM_CMP; i++) begin
         if (addr == ADDR_W'(RA_CMP_BASE + i)) rd_data = cmp_val[i];
      end
   end

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count)); // R1
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (count == $past(count) + CNT_W'(1))); // R1
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == {CNT_W{1'b1}}) |=> flags[FLG_OVF]); // R4
   AST_RTI_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rti_pulse |=> flags[FLG_RTI]); // R6
   AST_W1C_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (we_flags && wr_data[FLG_W-1:0] == '0 && set_mask == '0) |=> $stable(flags)); // R7
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (enables == '0) |-> !irq); // R8

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_chk
      AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
         cmp_hit[i] |=> flags[FLG_CMP_BASE + i]); // R5
   end
endmodule

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;
   localparam int CW = 8;
   localparam int NC = 2;
   localparam int AW = 4;
   localparam int RB = 4;
   localparam int MSK = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] rd_data;
   logic          irq;

   int checks = 0;
   int errs   = 0;
   int cyc    = 0;

   prescaled_timer #(.CNT_W(CW), .NUM_CMP(NC), .RTI_BASE_LOG2(RB),
                     .LOCK_CYCLES(64), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output int v);
      addr = AW'(a);
      #0.1;
      v = int'(rd_data);
   endtask

   task automatic wr(input int a, input int d);
      wr_en   = 1'b1;
      addr    = AW'(a);
      wr_data = CW'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_count(input int target);
      int c;
      forever begin
         rd(0, c);
         if (c == target) break;
         @(negedge clk);
      end
   endtask

   // measure spacing of counter increments: expect gap d, step 1
   task automatic measure_div(input int d, input string req);
      int prev, v, lastc, n;
      prev = -1; lastc = -1; n = 0;
      while (n < 6) begin
         @(negedge clk);
         rd(0, v);
         if (prev >= 0 && v != prev) begin
            chk(v == ((prev + 1) & MSK), "R1 step", v, (prev + 1) & MSK);
            if (lastc >= 0) chk(cyc - lastc == d, req, cyc - lastc, d);
            lastc = cyc;
            n++;
         end
         prev = v;
      end
   endtask

   initial begin
      #(200000 * 5);
      errs++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      int v, f, c;
      @(negedge clk);
      do_reset();
      // R9 reset state, R10 read mux
      rd(0, v); chk(v == 0, "R9 count", v, 0);
      rd(1, v); chk(v == 0, "R9 ctrl", v, 0);
      rd(2, v); chk(v == 0, "R9 flags", v, 0);
      rd(3, v); chk(v == 0, "R9 enables", v, 0);
      rd(4, v); chk(v == MSK, "R9 cmp0", v, MSK);
      rd(5, v); chk(v == MSK, "R9 cmp1", v, MSK);
      rd(15, v); chk(v == 0, "R10 unmapped", v, 0);
      chk(irq == 1'b0, "R9 irq", int'(irq), 0);

      // R2 prescaler sweep over all codes
      for (int s = 0; s < 4; s++) begin
         do_reset();
         wr(1, s << 2);
         rd(1, v); chk(v == (s << 2), "R2 ctrl readback", v, s << 2);
         measure_div((s == 0) ? 1 : (4 << (s - 1)), "R2 gap");
         if (s == 0) begin
            rd(0, c);
            wr(0, 8'hA5);
            rd(0, v); chk(v == ((c + 1) & MSK), "R1 write ignored", v, (c + 1) & MSK);
         end
      end

      // R3 prescaler lock after 64 cycles
      do_reset();
      wr(1, 1 << 2);
      repeat (70) @(negedge clk);
      wr(1, (3 << 2) | 2);
      rd(1, v); chk(v == ((1 << 2) | 2), "R3 ctrl locked", v, (1 << 2) | 2);
      measure_div(4, "R3 gap unchanged");

      // R4 overflow at divide-by-1
      do_reset();
      wait_count(MSK);
      rd(2, f); chk((f & 1) == 0, "R4 before wrap", f & 1, 0);
      @(negedge clk);
      rd(0, c); chk(c == 0, "R4 wrapped count", c, 0);
      rd(2, f); chk((f & 1) == 1, "R4 flag set", f & 1, 1);

      // R5 compare sweep
      for (int k = 0; k < 6; k++) begin
         int cv;
         cv = (k * 41 + 7) & MSK;
         wr(4, cv);
         wr(5, (cv + 1) & MSK);
         wait_count((cv - 20) & MSK);
         wr(2, 15);
         wait_count(cv);
         rd(2, f); chk(((f >> 2) & 1) == 0, "R5 not yet", (f >> 2) & 1, 0);
         @(negedge clk);
         rd(0, c); chk(c == ((cv + 1) & MSK), "R5 count", c, (cv + 1) & MSK);
         rd(2, f); chk(((f >> 2) & 3) == 1, "R5 ch0 set ch1 clear", (f >> 2) & 3, 1);
         @(negedge clk);
         rd(2, f); chk(((f >> 3) & 1) == 1, "R5 ch1 set", (f >> 3) & 1, 1);
      end

      // R7 write-one-to-clear
      wr(2, 0);
      rd(2, f); chk(((f >> 2) & 3) == 3, "R7 zero write", (f >> 2) & 3, 3);
      wr(2, 4);
      rd(2, f); chk(((f >> 2) & 3) == 2, "R7 clear ch0 only", (f >> 2) & 3, 2);

      // R8 interrupt gating
      wr(3, 8);
      #0.1; chk(irq == 1'b1, "R8 enabled set", int'(irq), 1);
      wr(3, 4);
      #0.1; chk(irq == 1'b0, "R8 disabled set", int'(irq), 0);
      rd(3, v); chk(v == 4, "R8 enable readback", v, 4);
      wr(3, 8);
      wr(2, 8);
      #0.1; chk(irq == 1'b0, "R8 cleared", int'(irq), 0);
      wr(3, 0);

      // R6 real-time rate sweep
      for (int r = 0; r < 4; r++) begin
         int n, last, p;
         p = (1 << RB) << r;
         wr(1, r);
         rd(1, v); chk(v == r, "R6 rate writable", v, r);
         wr(2, 2);
         n = 0; last = -1;
         while (n < 5) begin
            @(negedge clk);
            rd(2, f);
            if ((f & 2) != 0) begin
               if (n >= 2) chk(cyc - last == p, "R6 period", cyc - last, p);
               last = cyc;
               n++;
               wr(2, 2);
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule